// File: doc/BRIEF.md
# Memory Security Attribution Lookup

This block sorts every 32-bit address it is given into one of three security classes: Secure, Non-secure, or Non-secure-Callable. Software programs a small table of address windows through a register write port. An external, implementation-defined attribution source can also supply its own verdict for the same address. The block merges the two, and the external source may only ever make the result more secure.

A lookup is presented on the input pins and its result appears on registered outputs one clock later. Every window in the table is compared in parallel. The result carries:
- the class;
- the number of the matching window, when exactly one window matched;
- the external source's region number, copied through when the source marks it valid;
- a subpage flag.

The subpage flag tells a downstream translation cache that the result does not hold for the whole page around the address, so a single cache entry must not cover that page.

Some addresses bypass the table entirely. Instruction fetches from the top 256 MiB of the address space are always Secure. A fixed set of system windows, and any address the external source marks as exempt, simply take the security state of the current access.

Top module: `sec_attr_lookup`

## Requirements
- R1: Reset clears the control register, every window register and every output, so the control register starts with ENABLE=0 and ALLNS=0 and every ordinary address is Secure. Register write map, by selector value: 0 is the control register, with ENABLE in bit 0 and ALLNS in bit 1; 2+2*r is the base register of window r; 3+2*r is the limit register of window r.
- R2: An instruction fetch whose address bits [31:28] equal 4'hF yields all outputs zero, whatever the other inputs are.
- R3: An address is exempt if the external exempt input is high, or if it falls in one of the fixed system windows, bounds inclusive: E0000000-E0002FFF, E000E000-E000EFFF, E002E000-E002EFFF, E0040000-E0041FFF, E00FF000-E00FFFFF. For an exempt address, ns equals the inverse of the current security input and every other output is zero.
- R4: When ENABLE=0 the table plays no part. With ALLNS=0 every ordinary address is Secure; with ALLNS=1 every ordinary address is Non-secure. When ENABLE=1 the table decides, whatever the value of ALLNS.
- R5: A window takes part only when bit 0 of its limit register is 1. Its lower bound is the base register with bits [4:0] forced to 0; its upper bound is the limit register with bits [4:0] forced to 1. Both bounds are inclusive.
- R6: When exactly one window matches, bit 1 of its limit register chooses the class: 1 gives Non-secure-Callable and 0 gives Non-secure. The window-valid output is then 1 and the window number output holds the window's index.
- R7: When two or more windows match, the result is Secure: nsc is 0, the window number is 0 and window-valid is 0.
- R8: With ENABLE=1, subpage is 1 in either of two cases. The first is a matching window whose lower bound lies above the page base, or whose upper bound lies below the page end. The second is an enabled window that does not match, whose upper bound is not below its lower bound, and whose range overlaps the address's page. The page is 2^PAGE_BITS bytes and aligned.
- R9: For an ordinary address (one that is not exempt and not a top-region fetch), an external ns of 0 forces the output to Secure in two cases: when the table result is Non-secure, and when the table result is Non-secure-Callable while the external nsc is 0. Whenever the output is forced this way, nsc takes the external nsc value.
- R10: For an ordinary address with the external region-valid input high, the external region number and its valid flag appear on the outputs. In all other cases both are 0.
- R11: Each result appears on the outputs exactly one clock edge after the inputs are sampled. A window register written at one clock edge takes effect for lookups sampled at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | SEL_W | Register selector (map in R1) |
| cfg_wdata | input | 32 | Register write data |
| lk_addr | input | 32 | Address to classify |
| lk_fetch | input | 1 | Access is an instruction fetch |
| lk_secure | input | 1 | Current security state is Secure |
| ext_exempt | input | 1 | External source marks address exempt |
| ext_ns | input | 1 | External source reports Non-secure |
| ext_nsc | input | 1 | External source reports Non-secure-Callable |
| ext_rgn | input | EXT_W | External region number |
| ext_rgn_vld | input | 1 | External region number is valid |
| res_ns | output | 1 | Result is Non-secure |
| res_nsc | output | 1 | Result is Non-secure-Callable |
| res_rgn | output | IDX_W | Matching window index |
| res_rgn_vld | output | 1 | Window index is valid |
| res_ext_rgn | output | EXT_W | Copied external region number |
| res_ext_rgn_vld | output | 1 | Copied external region is valid |
| res_subpage | output | 1 | Result does not hold for the whole page |

## Verification
Every lookup result is due one clock edge after the edge that samples its inputs. Configuration writes land at their own edge and steer only the lookups sampled after it. The driver applies each lookup just after a falling edge and queues the expected result. The monitor pops that result a short delay after the following rising edge, so every comparison lands in the single cycle that the result occupies. Lookups are issued back to back, which shows that each result depends only on its own inputs and not on the previous ones.

// File: rtl/sec_attr_pkg.sv
package sec_attr_pkg;

  localparam int CTRL_ENABLE_BIT = 0;
  localparam int CTRL_ALLNS_BIT  = 1;
  localparam int LIM_EN_BIT      = 0;
  localparam int LIM_NSC_BIT     = 1;
  localparam int GRAN_BITS       = 5;
  localparam int HI_W            = 32 - GRAN_BITS;

  // Fixed system windows that bypass the attribution table.
  function automatic logic in_fixed_exempt(input logic [31:0] a);
    logic r;
    r = 1'b0;
    if (a >= 32'hE000_E000 && a <= 32'hE000_EFFF) r = 1'b1;
    if (a >= 32'hE00F_F000 && a <= 32'hE00F_FFFF) r = 1'b1;
    if (a >= 32'hE000_0000 && a <= 32'hE000_2FFF) r = 1'b1;
    if (a >= 32'hE004_0000 && a <= 32'hE004_1FFF) r = 1'b1;
    if (a >= 32'hE002_E000 && a <= 32'hE002_EFFF) r = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/sat_cfg_regs.sv
module sat_cfg_regs
  import sec_attr_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int SEL_W       = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [SEL_W-1:0]                  wr_sel,
  input  logic [31:0]                       wr_data,
  output logic [1:0]                        ctrl_q,
  output logic [NUM_REGIONS-1:0][HI_W-1:0]  base_hi_q,
  output logic [NUM_REGIONS-1:0][HI_W-1:0]  lim_hi_q,
  output logic [NUM_REGIONS-1:0]            rgn_en_q,
  output logic [NUM_REGIONS-1:0]            rgn_nsc_q
);

  logic       ctrl_ce;
  logic [1:0] ctrl_d;

  always_comb begin
    ctrl_ce = wr_en && (wr_sel == SEL_W'(0));
    ctrl_d  = ctrl_ce ? {wr_data[CTRL_ALLNS_BIT], wr_data[CTRL_ENABLE_BIT]} : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    logic            base_ce, lim_ce;
    logic [HI_W-1:0] base_d, lim_d;
    logic            en_d, nsc_d;

    always_comb begin
      base_ce = wr_en && (wr_sel == SEL_W'(2 + 2 * r));
      lim_ce  = wr_en && (wr_sel == SEL_W'(3 + 2 * r));
      base_d  = base_ce ? wr_data[31:GRAN_BITS] : base_hi_q[r];
      lim_d   = lim_ce  ? wr_data[31:GRAN_BITS] : lim_hi_q[r];
      en_d    = lim_ce  ? wr_data[LIM_EN_BIT]   : rgn_en_q[r];
      nsc_d   = lim_ce  ? wr_data[LIM_NSC_BIT]  : rgn_nsc_q[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_hi_q[r] <= '0;
        lim_hi_q[r]  <= '0;
        rgn_en_q[r]  <= 1'b0;
        rgn_nsc_q[r] <= 1'b0;
      end else begin
        base_hi_q[r] <= base_d;
        lim_hi_q[r]  <= lim_d;
        rgn_en_q[r]  <= en_d;
        rgn_nsc_q[r] <= nsc_d;
      end
    end
  end

  // R1: a write to selector 0 lands in the control register at the next edge
  a_r1_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_W'(0)) |=>
      ctrl_q == {$past(wr_data[CTRL_ALLNS_BIT]), $past(wr_data[CTRL_ENABLE_BIT])});

endmodule

// File: rtl/sat_region_cmp.sv
module sat_region_cmp
  import sec_attr_pkg::*;
#(
  parameter int PAGE_BITS = 10
) (
  input  logic [31:0]     addr,
  input  logic [HI_W-1:0] base_hi,
  input  logic [HI_W-1:0] lim_hi,
  input  logic            en,
  output logic            hit,
  output logic            partial
);

  logic [31:0] lo, hi, pg_lo, pg_hi;
  logic        overlap;

  always_comb begin
    lo      = {base_hi, {GRAN_BITS{1'b0}}};
    hi      = {lim_hi, {GRAN_BITS{1'b1}}};
    pg_lo   = {addr[31:PAGE_BITS], {PAGE_BITS{1'b0}}};
    pg_hi   = {addr[31:PAGE_BITS], {PAGE_BITS{1'b1}}};
    hit     = en && (lo <= addr) && (addr <= hi);
    overlap = (hi >= lo) && (lo <= pg_hi) && (hi >= pg_lo);
    if (!en)
      partial = 1'b0;
    else if (hit)
      partial = (lo > pg_lo) || (hi < pg_hi);
    else
      partial = overlap;
  end

endmodule

// File: rtl/sat_resolve.sv
module sat_resolve
  import sec_attr_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3,
  parameter int EXT_W       = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [31:0]            addr,
  input  logic                   is_fetch,
  input  logic                   cur_secure,
  input  logic                   ext_exempt,
  input  logic                   ext_ns,
  input  logic                   ext_nsc,
  input  logic [EXT_W-1:0]       ext_rgn,
  input  logic                   ext_rgn_vld,
  input  logic [1:0]             ctrl,
  input  logic [NUM_REGIONS-1:0] hit,
  input  logic [NUM_REGIONS-1:0] partial,
  input  logic [NUM_REGIONS-1:0] rgn_nsc,
  output logic                   ns_d,
  output logic                   nsc_d,
  output logic [IDX_W-1:0]       rgn_d,
  output logic                   rgn_vld_d,
  output logic [EXT_W-1:0]       ext_rgn_d,
  output logic                   ext_vld_d,
  output logic                   subpage_d
);

  logic             fetch_hi, exempt, any_hit, multi_hit, hit_nsc;
  logic [IDX_W-1:0] hit_idx;

  // Lowest-index hit, and whether a second hit exists.
  always_comb begin
    any_hit   = 1'b0;
    multi_hit = 1'b0;
    hit_idx   = '0;
    hit_nsc   = 1'b0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (hit[r]) begin
        if (any_hit) multi_hit = 1'b1;
        else begin
          hit_idx = IDX_W'(r);
          hit_nsc = rgn_nsc[r];
        end
        any_hit = 1'b1;
      end
    end
  end

  always_comb begin
    fetch_hi  = is_fetch && (addr[31:28] == 4'hF);
    exempt    = ext_exempt || in_fixed_exempt(addr);
    ns_d      = 1'b0;
    nsc_d     = 1'b0;
    rgn_d     = '0;
    rgn_vld_d = 1'b0;
    ext_rgn_d = '0;
    ext_vld_d = 1'b0;
    subpage_d = 1'b0;
    if (fetch_hi) begin
      ns_d = 1'b0;
    end else if (exempt) begin
      ns_d = !cur_secure;
    end else begin
      if (ext_rgn_vld) begin
        ext_rgn_d = ext_rgn;
        ext_vld_d = 1'b1;
      end
      if (ctrl[CTRL_ENABLE_BIT]) begin
        subpage_d = |partial;
        if (any_hit && !multi_hit) begin
          ns_d      = !hit_nsc;
          nsc_d     = hit_nsc;
          rgn_d     = hit_idx;
          rgn_vld_d = 1'b1;
        end
      end else if (ctrl[CTRL_ALLNS_BIT]) begin
        ns_d = 1'b1;
      end
      // External source may only raise the security level.
      if (!ext_ns && (ns_d || (!ext_nsc && nsc_d))) begin
        ns_d  = 1'b0;
        nsc_d = ext_nsc;
      end
    end
  end

  // R7: several matching windows give Secure with no window number
  a_r7_multi_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CTRL_ENABLE_BIT] && !fetch_hi && !exempt && $countones(hit) > 1) |->
      (!ns_d && !nsc_d && !rgn_vld_d && rgn_d == '0));

  // R4: table disabled without ALLNS leaves ordinary addresses Secure
  a_r4_off_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == 2'b00 && !fetch_hi && !exempt) |->
      (!ns_d && !nsc_d && !rgn_vld_d && !subpage_d));

  // R6: a window number is reported only with exactly one hit
  a_r6_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_vld_d |-> ($countones(hit) == 1 && hit[rgn_d]));

endmodule

// File: rtl/sec_attr_lookup.sv
module sec_attr_lookup
  import sec_attr_pkg::*;
#(
  parameter  int NUM_REGIONS = 8,
  parameter  int PAGE_BITS   = 10,
  parameter  int EXT_W       = 8,
  localparam int SEL_W       = $clog2(2 * NUM_REGIONS + 2),
  localparam int IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic [31:0]      lk_addr,
  input  logic             lk_fetch,
  input  logic             lk_secure,
  input  logic             ext_exempt,
  input  logic             ext_ns,
  input  logic             ext_nsc,
  input  logic [EXT_W-1:0] ext_rgn,
  input  logic             ext_rgn_vld,
  output logic             res_ns,
  output logic             res_nsc,
  output logic [IDX_W-1:0] res_rgn,
  output logic             res_rgn_vld,
  output logic [EXT_W-1:0] res_ext_rgn,
  output logic             res_ext_rgn_vld,
  output logic             res_subpage
);

  logic [1:0]                       ctrl_q;
  logic [NUM_REGIONS-1:0][HI_W-1:0] base_hi_q, lim_hi_q;
  logic [NUM_REGIONS-1:0]           rgn_en_q, rgn_nsc_q;
  logic [NUM_REGIONS-1:0]           hit, partial;

  logic             ns_d, nsc_d, rgn_vld_d, ext_vld_d, subpage_d;
  logic [IDX_W-1:0] rgn_d;
  logic [EXT_W-1:0] ext_rgn_d;

  sat_cfg_regs #(.NUM_REGIONS(NUM_REGIONS), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata), .ctrl_q(ctrl_q), .base_hi_q(base_hi_q),
    .lim_hi_q(lim_hi_q), .rgn_en_q(rgn_en_q), .rgn_nsc_q(rgn_nsc_q)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
    sat_region_cmp #(.PAGE_BITS(PAGE_BITS)) u_cmp (
      .addr(lk_addr), .base_hi(base_hi_q[r]), .lim_hi(lim_hi_q[r]),
      .en(rgn_en_q[r]), .hit(hit[r]), .partial(partial[r])
    );
  end

  sat_resolve #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W), .EXT_W(EXT_W)) u_res (
    .clk(clk), .rst_n(rst_n), .addr(lk_addr), .is_fetch(lk_fetch),
    .cur_secure(lk_secure), .ext_exempt(ext_exempt), .ext_ns(ext_ns),
    .ext_nsc(ext_nsc), .ext_rgn(ext_rgn), .ext_rgn_vld(ext_rgn_vld),
    .ctrl(ctrl_q), .hit(hit), .partial(partial), .rgn_nsc(rgn_nsc_q),
    .ns_d(ns_d), .nsc_d(nsc_d), .rgn_d(rgn_d), .rgn_vld_d(rgn_vld_d),
    .ext_rgn_d(ext_rgn_d), .ext_vld_d(ext_vld_d), .subpage_d(subpage_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_ns          <= 1'b0;
      res_nsc         <= 1'b0;
      res_rgn         <= '0;
      res_rgn_vld     <= 1'b0;
      res_ext_rgn     <= '0;
      res_ext_rgn_vld <= 1'b0;
      res_subpage     <= 1'b0;
    end else begin
      res_ns          <= ns_d;
      res_nsc         <= nsc_d;
      res_rgn         <= rgn_d;
      res_rgn_vld     <= rgn_vld_d;
      res_ext_rgn     <= ext_rgn_d;
      res_ext_rgn_vld <= ext_vld_d;
      res_subpage     <= subpage_d;
    end
  end

  // R2: top-region fetches clear every output one cycle later
  a_r2_fetch_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fetch && lk_addr[31:28] == 4'hF) |=>
      (!res_ns && !res_nsc && !res_rgn_vld && res_rgn == '0 &&
       !res_ext_rgn_vld && !res_subpage));

  // R3: exempt addresses follow the current security state only
  a_r3_exempt_state: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_exempt && !(lk_fetch && lk_addr[31:28] == 4'hF)) |=>
      (res_ns == !$past(lk_secure) && !res_nsc && !res_rgn_vld &&
       !res_ext_rgn_vld && !res_subpage));

  // R9: an external Secure verdict never yields a Non-secure result
  a_r9_raise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_ns && !ext_exempt && !in_fixed_exempt(lk_addr) &&
     !(lk_fetch && lk_addr[31:28] == 4'hF)) |=> !res_ns);

  // R6: Non-secure and Non-secure-Callable are never reported together
  a_r6_class_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_ns, res_nsc}));

endmodule

// File: tb/tb_sec_attr_lookup.sv
module tb_sec_attr_lookup;

  typedef struct packed {
    logic       ns;
    logic       nsc;
    logic [2:0] rgn;
    logic       rv;
    logic [7:0] er;
    logic       ev;
    logic       sp;
  } exp_t;

  logic        clk, rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_sel;
  logic [31:0] cfg_wdata, lk_addr;
  logic        lk_fetch, lk_secure, ext_exempt, ext_ns, ext_nsc, ext_rgn_vld;
  logic [7:0]  ext_rgn;
  logic        res_ns, res_nsc, res_rgn_vld, res_ext_rgn_vld, res_subpage;
  logic [2:0]  res_rgn;
  logic [7:0]  res_ext_rgn;

  int   n_tests, n_fail;
  bit   finished;
  exp_t exp_q[$];
  string tag_q[$];

  sec_attr_lookup dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .lk_addr(lk_addr), .lk_fetch(lk_fetch),
    .lk_secure(lk_secure), .ext_exempt(ext_exempt), .ext_ns(ext_ns),
    .ext_nsc(ext_nsc), .ext_rgn(ext_rgn), .ext_rgn_vld(ext_rgn_vld),
    .res_ns(res_ns), .res_nsc(res_nsc), .res_rgn(res_rgn),
    .res_rgn_vld(res_rgn_vld), .res_ext_rgn(res_ext_rgn),
    .res_ext_rgn_vld(res_ext_rgn_vld), .res_subpage(res_subpage)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic exp_t mk(logic ns, logic nsc, logic [2:0] rgn, logic rv,
                              logic [7:0] er, logic ev, logic sp);
    exp_t e;
    e.ns = ns; e.nsc = nsc; e.rgn = rgn; e.rv = rv;
    e.er = er; e.ev = ev; e.sp = sp;
    return e;
  endfunction

  function automatic exp_t got();
    return mk(res_ns, res_nsc, res_rgn, res_rgn_vld, res_ext_rgn,
              res_ext_rgn_vld, res_subpage);
  endfunction

  task automatic wr(input logic [4:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Driver: applies one lookup and queues its expected result.
  task automatic look(input logic [31:0] a, input logic f, input logic s,
                      input logic ex, input logic ens, input logic ensc,
                      input logic ev, input logic [7:0] er,
                      input exp_t e, input string tag);
    @(negedge clk);
    lk_addr = a; lk_fetch = f; lk_secure = s; ext_exempt = ex;
    ext_ns = ens; ext_nsc = ensc; ext_rgn_vld = ev; ext_rgn = er;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: the result is due at the rising edge after the drive.
  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e, g;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = got();
      n_tests++;
      if (g !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, g, e);
      end
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    lk_addr = '0; lk_fetch = 1'b0; lk_secure = 1'b1; ext_exempt = 1'b0;
    ext_ns = 1'b1; ext_nsc = 1'b1; ext_rgn_vld = 1'b0; ext_rgn = '0;
    repeat (3) @(negedge clk);
    n_tests++;
    if (got() !== mk(0, 0, 0, 0, 8'h00, 0, 0)) begin
      n_fail++;
      $display("FAIL R1 reset outputs: actual %h expected 0", got());
    end
    rst_n = 1'b1;

    // R1: after reset the table is off and ALLNS clear: Secure
    look(32'h0000_1000, 0, 0, 0, 1, 1, 0, 8'h00, mk(0,0,0,0,8'h00,0,0), "R1 reset Secure");
    // R4: ALLNS with table disabled
    wr(5'd0, 32'h0000_0002);
    look(32'h0000_1000, 0, 1, 0, 1, 1, 0, 8'h00, mk(1,0,0,0,8'h00,0,0), "R4 allns");
    // R9: external Secure with nsc raises Non-secure to NSC
    look(32'h0000_1000, 0, 1, 0, 0, 1, 0, 8'h00, mk(0,1,0,0,8'h00,0,0), "R9 raise to nsc");
    // R2: top-region fetch clears everything
    look(32'hF000_1000, 1, 0, 0, 0, 0, 1, 8'h77, mk(0,0,0,0,8'h00,0,0), "R2 fetch top");
    // R3: fixed windows and external exempt
    look(32'hE000_E010, 0, 1, 0, 1, 1, 1, 8'h33, mk(0,0,0,0,8'h00,0,0), "R3 exempt secure");
    look(32'hE000_E010, 0, 0, 0, 1, 1, 0, 8'h00, mk(1,0,0,0,8'h00,0,0), "R3 exempt nonsecure");
    look(32'hE000_2FFF, 0, 1, 0, 1, 1, 0, 8'h00, mk(0,0,0,0,8'h00,0,0), "R3 window end");
    look(32'hE000_3000, 0, 1, 0, 1, 1, 0, 8'h00, mk(1,0,0,0,8'h00,0,0), "R3 past window");
    look(32'h0000_1000, 0, 1, 1, 1, 1, 0, 8'h00, mk(0,0,0,0,8'h00,0,0), "R3 ext exempt");

    // R5/R6: window 0 = 2000..23FF NS, window 1 = 3020..305F NSC, window 3 disabled
    wr(5'd2, 32'h0000_2000); wr(5'd3, 32'h0000_23E1);
    wr(5'd4, 32'h0000_3020); wr(5'd5, 32'h0000_3043);
    wr(5'd8, 32'h0000_5000); wr(5'd9, 32'h0000_5FE0);
    wr(5'd0, 32'h0000_0001);
    look(32'h0000_2000, 0, 1, 0, 1, 1, 0, 8'h00, mk(1,0,0,1,8'h00,0,0), "R5 lower bound");
    look(32'h0000_23FF, 0, 1, 0, 1, 1, 0, 8'h00, mk(1,0,0,1,8'h00,0,0), "R5 upper bound");
    look(32'h0000_1FFF, 0, 1, 0, 1, 1, 0, 8'h00, mk(0,0,0,0,8'h00,0,0), "R5 below");
    look(32'h0000_3020, 0, 1, 0, 1, 1, 0, 8'h00, mk(0,1,1,1,8'h00,0,1), "R6 nsc hit");
    look(32'h0000_301F, 0, 1, 0, 1, 1, 0, 8'h00, mk(0,0,0,0,8'h00,0,1), "R8 miss overlap");
    look(32'h0000_3060, 0, 1, 0, 1, 1, 0, 8'h00, mk(0,0,0,0,8'h00,0,1), "R8 past limit");
    look(32'h0000_3040, 0, 1, 0, 0, 0, 0, 8'h00, mk(0,0,1,1,8'h00,0,1), "R9 force secure");
    look(32'h0000_3040, 0, 1, 0, 0, 1, 0, 8'h00, mk(0,1,1,1,8'h00,0,1), "R9 keep nsc");
    look(32'h0000_2000, 0, 1, 0, 1, 1, 1, 8'h5A, mk(1,0,0,1,8'h5A,1,0), "R10 ext region");
    look(32'h0000_5100, 0, 1, 0, 1, 1, 0, 8'h00, mk(0,0,0,0,8'h00,0,0), "R5 disabled window");
    // R11: back-to-back different results
    look(32'h0000_2000, 0, 1, 0, 1, 1, 0, 8'h00, mk(1,0,0,1,8'h00,0,0), "R11 first");
    look(32'h0000_1FFF, 0, 1, 0, 1, 1, 0, 8'h00, mk(0,0,0,0,8'h00,0,0), "R11 second");

    // R7: window 2 = 2200..22FF overlaps window 0
    wr(5'd6, 32'h0000_2200); wr(5'd7, 32'h0000_22E1);
    look(32'h0000_2250, 0, 1, 0, 1, 1, 0, 8'h00, mk(0,0,0,0,8'h00,0,1), "R7 multi hit");
    look(32'h0000_2100, 0, 1, 0, 1, 1, 0, 8'h00, mk(1,0,0,1,8'h00,0,1), "R8 neighbour partial");
    // R4: ENABLE with ALLNS still uses the table
    wr(5'd0, 32'h0000_0003);
    look(32'h0000_1FFF, 0, 1, 0, 1, 1, 0, 8'h00, mk(0,0,0,0,8'h00,0,0), "R4 enable wins");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule